// File: doc/BRIEF.md
# Single-Bit In-Place Repair Register

This block is an n-bit data register that can repair one upset bit in place. A separate checksum detector watches the register. Each data bit has an address: bit `i` carries address `i+1`. The checksum of a value is the bitwise XOR of the addresses of all bits that are set. When the stored checksum and the freshly computed checksum disagree, and the detector has ruled out an upset in its own reference storage, it raises `correct` and presents their XOR on `diff`. That XOR is the address of the bit that flipped.

The register gates `diff` with `correct` and decodes it into a one-hot repair vector. At the next clock edge it inverts exactly the addressed bit and leaves every other bit unchanged. During that one cycle it drives `stall`, which freezes the surrounding logic so the repair costs a single clock. When no repair is requested, data reaches the register through its load enable alone and no cycle is lost.

An address of 0, or an address above the width, cannot point at a real bit. Such an address can appear after a multi-bit upset. It is never applied. Instead it raises `uncorrectable` so that a higher level can replay the computation.

Top module: `bitflip_repair_reg`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros and both `stall` and `uncorrectable` are low.
- R2: With `correct` low and `load` high, `q` takes `d_in` at the next rising edge, and `stall` stays low, so no cycle is added.
- R3: With `correct` and `load` both low, `q` holds its value whatever `diff` carries. This covers an upset in the detector's reference or parity, where the data must be left alone.
- R4: With `correct` high and `diff` = k, where 1 <= k <= DATA_W, bit k-1 of `q` is inverted at the next rising edge and every other bit keeps its value.
- R5: `stall` is high in the same cycle as a valid repair request, meaning `correct` high and `diff` in 1..DATA_W, and low in every other cycle.
- R6: When `load` and a valid repair request arrive in the same cycle, the repair is applied and that cycle's `d_in` is discarded.
- R7: With `correct` high and `diff` equal to 0 or above DATA_W, `uncorrectable` is high in that cycle, `stall` is low, no bit is flipped, and `load` acts as in R2 and R3.
- R8: After a repair, the address checksum of `q` equals its previous checksum XOR `diff`. For a single upset, this restores the reference checksum for every bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_in | input | DATA_W | Functional data to store |
| load | input | 1 | Functional write enable |
| correct | input | 1 | Detector says the data path was hit |
| diff | input | CKS_W | Reference XOR current checksum (address of the bad bit) |
| q | output | DATA_W | Stored data |
| stall | output | 1 | Freeze request for the surrounding registers during a repair |
| uncorrectable | output | 1 | Repair request with an address that points at no bit |

## Verification
A wrong decode shows up at `q` one edge after the request, in one of two ways. Either the wrong bit flips, or two bits flip, which the checksum comparison then exposes because the result no longer equals the reference. A wrong `stall` or `uncorrectable` is visible combinationally in the very cycle of the request. A broken priority between repair and load shows in the next cycle, because `q` then holds `d_in` instead of the repaired word. Every bit position is repaired once from a known reference, and random traffic mixes loads, repairs and illegal addresses.

// File: rtl/bfr_pkg.sv
package bfr_pkg;
  // Largest supported register width; checksums are carried in 7 bits.
  localparam int unsigned MAX_W = 63;

  // XOR of the addresses (index + 1) of all set bits among the lowest n bits.
  function automatic logic [6:0] addr_checksum(input logic [63:0] v, input int unsigned n);
    logic [6:0] c;
    c = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < n && v[i]) c = c ^ 7'(i + 1);
    end
    return c;
  endfunction

  // Does an address select a real bit of an n-bit register?
  function automatic logic addr_in_range(input logic [6:0] a, input int unsigned n);
    return (a != 7'd0) && (int'(a) <= n);
  endfunction
endpackage

// File: rtl/bfr_decoder.sv
module bfr_decoder #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CKS_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              correct,
  input  logic [CKS_W-1:0]  diff,
  output logic [DATA_W-1:0] fix_vec,
  output logic              fix_req,
  output logic              bad_addr
);
  logic [CKS_W-1:0] gated_diff;
  logic             in_range;

  // The difference is only looked at when the detector asks for a repair.
  assign gated_diff = correct ? diff : '0;
  assign in_range   = bfr_pkg::addr_in_range(7'(gated_diff), DATA_W);

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_line
      assign fix_vec[gi] = (gated_diff == CKS_W'(gi + 1));
    end
  endgenerate

  assign fix_req  = correct && in_range;
  assign bad_addr = correct && !in_range;

  // R4: the repair vector never selects more than one bit
  p_onehot_fix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fix_vec));
  // R7: an illegal address drives no repair line and no freeze
  p_bad_no_fix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |-> (fix_vec == '0) && !fix_req);
  // R5: a repair request always selects exactly one bit
  p_req_one_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fix_req |-> ($countones(fix_vec) == 1));
endmodule

// File: rtl/bfr_bit.sv
module bfr_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic ld,
  input  logic flip,
  output logic q
);
  // A flip inverts the held value; otherwise the enable chooses new data.
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= 1'b0;
    else if (flip) q <= ~q;
    else if (ld)   q <= d;
  end
endmodule

// File: rtl/bitflip_repair_reg.sv
module bitflip_repair_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CKS_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] d_in,
  input  logic              load,
  input  logic              correct,
  input  logic [CKS_W-1:0]  diff,
  output logic [DATA_W-1:0] q,
  output logic              stall,
  output logic              uncorrectable
);
  logic [DATA_W-1:0] fix_vec;
  logic              fix_req;
  logic              bad_addr;
  logic              load_ok;

  bfr_decoder #(.DATA_W(DATA_W), .CKS_W(CKS_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .correct  (correct),
    .diff     (diff),
    .fix_vec  (fix_vec),
    .fix_req  (fix_req),
    .bad_addr (bad_addr)
  );

  // A pending repair stalls the functional write of the same cycle.
  assign load_ok       = load && !fix_req;
  assign stall         = fix_req;
  assign uncorrectable = bad_addr;

  genvar gb;
  generate
    for (gb = 0; gb < DATA_W; gb++) begin : g_bit
      bfr_bit u_bit (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (d_in[gb]),
        .ld   (load_ok),
        .flip (fix_vec[gb]),
        .q    (q[gb])
      );
    end
  endgenerate

  // R2: a plain write lands one edge later
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !correct) |=> (q == $past(d_in)));
  // R3: without load or repair the contents hold, whatever diff is
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !correct) |=> $stable(q));
  // R4: the flagged bit, and only that bit, inverts
  p_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (q == ($past(q) ^ $past(fix_vec))));
  // R6: a repair beats a same-cycle load; exactly one bit changes
  p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && load) |=> ($countones(q ^ $past(q)) == 1));
  // R7: an illegal address never freezes the neighbours
  p_uncorr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uncorrectable |-> !stall);
  // R7: an illegal address with no load leaves the data alone
  p_uncorr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uncorrectable && !load) |=> $stable(q));
  // R8: the checksum moves by exactly the repaired address
  p_cks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (bfr_pkg::addr_checksum(64'(q), DATA_W) ==
               (bfr_pkg::addr_checksum(64'($past(q)), DATA_W) ^ 7'($past(diff)))));

  initial begin
    p_width_ok: assert (DATA_W >= 1 && DATA_W <= bfr_pkg::MAX_W);
  end
endmodule

// File: tb/bitflip_repair_reg_test.sv
`timescale 1ns/1ps
module bitflip_repair_reg_test;
  localparam int unsigned N  = 8;
  localparam int unsigned CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  d_in = '0;
  logic          load = 1'b0;
  logic          correct = 1'b0;
  logic [CW-1:0] diff = '0;
  logic [N-1:0]  q;
  logic          stall;
  logic          uncorrectable;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model = '0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  bitflip_repair_reg #(.DATA_W(N), .CKS_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .d_in(d_in), .load(load), .correct(correct),
    .diff(diff), .q(q), .stall(stall), .uncorrectable(uncorrectable)
  );

  // Checksum by address bit: bit b is the parity of the data bits whose address has bit b set.
  function automatic logic [CW-1:0] ref_cks(input logic [N-1:0] v);
    logic [CW-1:0] c;
    for (int b = 0; b < CW; b++) begin
      logic p;
      p = 1'b0;
      for (int i = 0; i < N; i++) if (((i + 1) >> b) & 1) p = p ^ v[i];
      c[b] = p;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, check the same-cycle flags, then the stored word after the edge.
  task automatic step(input logic ld, input logic [N-1:0] d, input logic cr,
                      input logic [CW-1:0] df, input string tag);
    logic valid;
    @(negedge clk);
    load = ld; d_in = d; correct = cr; diff = df;
    #1;
    valid = cr && (df != 0) && (int'(df) <= N);
    check({"R5 stall ", tag}, 64'(stall), 64'(valid));
    check({"R7 uncorrectable ", tag}, 64'(uncorrectable), 64'(cr && !valid));
    if (valid)   model = model ^ (N'(1) << (df - 1));
    else if (ld) model = d;
    @(posedge clk);
    #1;
    check({"q ", tag}, 64'(q), 64'(model));
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    check("R1 q", 64'(q), 0);
    check("R1 stall", 64'(stall), 0);
    check("R1 uncorrectable", 64'(uncorrectable), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 plain writes, R3 hold with a stray difference
    step(1, 8'hA5, 0, 0, "R2 load");
    step(0, 8'h3C, 0, 4'd3, "R3 hold with diff");
    step(0, 8'hFF, 0, 0, "R3 idle");

    // R4 and R8: repair every bit position from a known reference
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] good, bad;
      logic [CW-1:0] df;
      good = N'($urandom);
      bad  = good ^ (N'(1) << k);
      step(1, good, 0, 0, "R2 reference");
      step(1, bad, 0, 0, "R2 upset image");
      df = ref_cks(good) ^ ref_cks(bad);
      check("R8 diff addresses bit", 64'(df), 64'(k + 1));
      step(0, 0, 1, df, "R4 repair");
      check("R4 repaired word", 64'(q), 64'(good));
      check("R8 checksum restored", 64'(ref_cks(q)), 64'(ref_cks(good)));
    end

    // R6: repair wins over a same-cycle write
    step(1, 8'h0F, 0, 0, "R2 setup");
    step(1, 8'hF0, 1, 4'd8, "R6 repair beats load");
    check("R6 load discarded", 64'(q), 64'h8F);

    // R7: illegal addresses, with and without a write
    step(0, 8'h00, 1, 4'd0, "R7 zero addr");
    step(0, 8'h00, 1, 4'(N + 1), "R7 addr above width");
    step(1, 8'h5A, 1, 4'd15, "R7 load proceeds");
    check("R7 load applied", 64'(q), 64'h5A);

    // Random mix of writes, repairs and illegal addresses
    for (int it = 0; it < 400; it++) begin
      logic ld, cr;
      ld = 1'($urandom);
      cr = ($urandom % 3) == 0;
      step(ld, N'($urandom), cr, CW'($urandom), "random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule